// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the host side of a two-bank synchronous DRAM. After reset it drives the command pins through the power-up sequence the memory needs. First it holds a long idle period with the clock running. Then it precharges both banks, issues a burst of auto-refresh commands, and writes the mode register. Once the mode-write settling gap has expired, it raises `init_done`. From then on it keeps a refresh cadence of 4096 refreshes per 64 ms, which works out to one refresh roughly every 15.6 µs. The cycle counts come from the clock period and the nanosecond timing parameters.

User read and write scheduling belongs to another block. That block reaches the command bus through a request/grant pair. `bus_req` works like a valid signal and `bus_gnt` like a ready signal, with these back-pressure rules:
- A grant is given only after initialization, and only while no refresh is due or in progress.
- Once given, the grant is never withdrawn while the request stays high.
- A refresh that falls due while the user holds the bus waits until the user drops the request.
- The controller then precharges both banks, refreshes, and hands the bus back after the refresh recovery time.

`refresh_busy` marks the span during which the controller owns the bus for a refresh. CKE is held high at all times.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is asserted the command pins carry NOP, CKE is high, and `init_done`, `refresh_busy` and `bus_gnt` are low.
- R2: After reset release, only NOP is driven until the rising edge numbered PWR_CYC+1. On that edge a precharge-all appears, with A10 high and every other address bit low. PWR_CYC is the power-up time divided by the clock period.
- R3: The first refresh follows the precharge by TRP_CYC cycles. Exactly INIT_REFS refreshes (default 8) follow, each TRC_CYC cycles after the one before, with the address at zero. TRP_CYC and TRC_CYC are the ceilings of tRP and tRC in clocks.
- R4: The mode write comes TRC_CYC cycles after the last start-up refresh. Its address has A11..A7 at zero, the CAS latency field on A6..A4, the burst type on A3 and the burst length code on A2..A0. With the defaults (latency 2, sequential, length code 2) the address is 0x022.
- R5: `init_done` rises exactly MRD_CYC cycles after the mode write (default 3) and then stays high.
- R6: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP 0111, precharge 0010, refresh 0001, mode write 0000.
- R7: After `init_done`, a refresh falls due every REF_CYC cycles, where REF_CYC is the floor of 15625 ns over the clock period (781 at 50 MHz). With the bus free, the precharge-all of that refresh appears one cycle after it falls due.
- R8: Each periodic refresh is a precharge-all followed TRP_CYC cycles later by a refresh. `refresh_busy` is high from the precharge cycle until TRC_CYC cycles after the refresh.
- R9: `bus_gnt` rises one cycle after `bus_req` is seen while the controller is ready, idle and has no refresh due. It stays high while `bus_req` stays high, and falls one cycle after `bus_req` drops.
- R10: A refresh that falls due while the grant is held is not started until the cycle after `bus_gnt` falls. No grant is given while `refresh_busy` is high.
- R11: A request made before `init_done` is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | User asks for the command bus |
| bus_gnt | output | 1 | User owns the command bus |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address; A11 selects the bank, A10 selects all banks on precharge |
| sd_cke | output | 1 | Clock enable, held high |
| init_done | output | 1 | Start-up sequence complete |
| refresh_busy | output | 1 | Controller owns the bus for a refresh |

## Verification
The bench holds a request across the first refresh deadline. It then checks that the refresh waits for the release and starts exactly two cycles after the request drops. A controller that revoked the grant or ignored it would put a precharge on the bus while the user still drives it.

The bench raises a new request in the middle of a refresh. A design that granted it early would hand over the bus inside the tRC window.

The bench also pins the exact cycles of the start-up commands and of `init_done`. An off-by-one in the shared wait counter shows up as a command, or the ready flag, one cycle early or late. A ninth or a seventh start-up refresh shows up as a mismatched scoreboard entry.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE  = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_BSTOP = 4'b0110,
    CMD_NOP   = 4'b0111
  } sd_cmd_t;

  localparam logic [11:0] ADDR_ALL_BANKS = 12'h400;

  function automatic int ns_to_cyc_ceil(longint ns, longint period_ps);
    longint c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int ns_to_cyc_floor(longint ns, longint period_ps);
    longint c;
    c = (ns * 1000) / period_ps;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbr_refresh_timer.sv
module sbr_refresh_timer #(
  parameter int INTERVAL_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic due_o
);
  localparam int CW = $clog2(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] tick_cnt;
  logic          wrap;

  assign wrap = enable && (tick_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      due_o    <= 1'b0;
    end else begin
      if (enable) tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
      if (wrap)     due_o <= 1'b1;
      else if (ack) due_o <= 1'b0;
    end
  end

  // R7
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (due_o && !ack) |=> due_o);

endmodule

// File: rtl/sbr_bus_arbiter.sv
module sbr_bus_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ready,
  input  logic refresh_due,
  input  logic refresh_busy,
  output logic gnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gnt_o <= 1'b0;
    else if (gnt_o) gnt_o <= req;
    else            gnt_o <= req && ready && !refresh_due && !refresh_busy;
  end

  // R9
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o && req) |=> gnt_o);

  // R10
  gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_o && refresh_busy));

  // R11
  gnt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |-> ready);

endmodule

// File: rtl/sbr_sequencer.sv
module sbr_sequencer import sbr_pkg::*; #(
  parameter int          PWR_CYC   = 10000,
  parameter int          TRP_CYC   = 1,
  parameter int          TRC_CYC   = 4,
  parameter int          MRD_CYC   = 3,
  parameter int          INIT_REFS = 8,
  parameter logic [11:0] MODE_WORD = 12'h022
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refresh_due,
  input  logic        bus_owned,
  output logic        refresh_ack,
  output logic [3:0]  cmd_o,
  output logic [11:0] addr_o,
  output logic        ready_o,
  output logic        busy_o
);
  localparam int MAX_WAIT = max_of(max_of(PWR_CYC, TRC_CYC), max_of(TRP_CYC, MRD_CYC));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(INIT_REFS + 1);
  localparam int GAP_MAX  = max_of(max_of(TRC_CYC, TRP_CYC), MRD_CYC);
  localparam int GAP_W    = $clog2(GAP_MAX + 2);

  typedef enum logic [2:0] {
    PH_POWER, PH_INIT_REF, PH_MODE, PH_SETTLE, PH_IDLE, PH_RF_REF, PH_RF_DONE
  } phase_t;

  phase_t         phase;
  logic [CNT_W-1:0] wait_cnt;
  logic [REF_W-1:0] ref_cnt;
  sd_cmd_t        cmd_q;
  logic [11:0]    addr_q;
  logic           ready_q;
  logic           busy_q;

  assign refresh_ack = (phase == PH_RF_DONE) && (wait_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_POWER;
      wait_cnt <= CNT_W'(PWR_CYC);
      ref_cnt  <= '0;
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      ready_q  <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else begin
        unique case (phase)
          PH_POWER: begin
            cmd_q    <= CMD_PRE;
            addr_q   <= ADDR_ALL_BANKS;
            wait_cnt <= CNT_W'(TRP_CYC - 1);
            phase    <= PH_INIT_REF;
          end
          PH_INIT_REF: begin
            cmd_q    <= CMD_REF;
            wait_cnt <= CNT_W'(TRC_CYC - 1);
            ref_cnt  <= ref_cnt + 1'b1;
            if (ref_cnt == REF_W'(INIT_REFS - 1)) phase <= PH_MODE;
          end
          PH_MODE: begin
            cmd_q    <= CMD_MODE;
            addr_q   <= MODE_WORD;
            wait_cnt <= CNT_W'(MRD_CYC - 1);
            phase    <= PH_SETTLE;
          end
          PH_SETTLE: begin
            ready_q <= 1'b1;
            phase   <= PH_IDLE;
          end
          PH_IDLE: begin
            if (refresh_due && !bus_owned) begin
              cmd_q    <= CMD_PRE;
              addr_q   <= ADDR_ALL_BANKS;
              busy_q   <= 1'b1;
              wait_cnt <= CNT_W'(TRP_CYC - 1);
              phase    <= PH_RF_REF;
            end
          end
          PH_RF_REF: begin
            cmd_q    <= CMD_REF;
            wait_cnt <= CNT_W'(TRC_CYC - 1);
            phase    <= PH_RF_DONE;
          end
          PH_RF_DONE: begin
            busy_q <= 1'b0;
            phase  <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign cmd_o   = cmd_q;
  assign addr_o  = addr_q;
  assign ready_o = ready_q;
  assign busy_o  = busy_q;

  // Cycles since the last refresh, precharge and mode write on the pins (saturating).
  logic [GAP_W-1:0] gap_ref, gap_pre, gap_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_ref  <= '1;
      gap_pre  <= '1;
      gap_mode <= '1;
    end else begin
      gap_ref  <= (cmd_q == CMD_REF)  ? GAP_W'(1) : ((gap_ref  == '1) ? gap_ref  : gap_ref  + 1'b1);
      gap_pre  <= (cmd_q == CMD_PRE)  ? GAP_W'(1) : ((gap_pre  == '1) ? gap_pre  : gap_pre  + 1'b1);
      gap_mode <= (cmd_q == CMD_MODE) ? GAP_W'(1) : ((gap_mode == '1) ? gap_mode : gap_mode + 1'b1);
    end
  end

  // R3
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |-> (gap_ref >= GAP_W'(TRC_CYC)));

  // R3
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |-> (gap_pre >= GAP_W'(TRP_CYC)));

  // R4
  mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MODE) |-> (addr_q[11:7] == 5'b0));

  // R5
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> (gap_mode == GAP_W'(MRD_CYC)));

  // R5
  ready_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

  // R8
  busy_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF && ready_q) |-> busy_q);

endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh import sbr_pkg::*; #(
  parameter int         CLK_PERIOD_PS   = 20000,
  parameter int         POWERUP_NS      = 200000,
  parameter int         TRP_NS          = 20,
  parameter int         TRC_NS          = 70,
  parameter int         MRD_CYC         = 3,
  parameter int         INIT_REFS       = 8,
  parameter int         REF_INTERVAL_NS = 15625,
  parameter logic [2:0] CAS_LAT         = 3'd2,
  parameter logic       BURST_TYPE      = 1'b0,
  parameter logic [2:0] BURST_LEN       = 3'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  output logic        bus_gnt,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [11:0] sd_addr,
  output logic        sd_cke,
  output logic        init_done,
  output logic        refresh_busy
);
  localparam int PWR_CYC = ns_to_cyc_ceil(POWERUP_NS, CLK_PERIOD_PS);
  localparam int TRP_CYC = ns_to_cyc_ceil(TRP_NS, CLK_PERIOD_PS);
  localparam int TRC_CYC = ns_to_cyc_ceil(TRC_NS, CLK_PERIOD_PS);
  localparam int REF_CYC = ns_to_cyc_floor(REF_INTERVAL_NS, CLK_PERIOD_PS);
  localparam logic [11:0] MODE_WORD = {5'b0, CAS_LAT, BURST_TYPE, BURST_LEN};

  logic       due, ack;
  logic [3:0] cmd;

  sbr_refresh_timer #(.INTERVAL_CYC(REF_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .enable(init_done), .ack(ack), .due_o(due)
  );

  sbr_bus_arbiter arb_i (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .ready(init_done),
    .refresh_due(due), .refresh_busy(refresh_busy), .gnt_o(bus_gnt)
  );

  sbr_sequencer #(
    .PWR_CYC(PWR_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC),
    .MRD_CYC(MRD_CYC), .INIT_REFS(INIT_REFS), .MODE_WORD(MODE_WORD)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .refresh_due(due), .bus_owned(bus_gnt),
    .refresh_ack(ack), .cmd_o(cmd), .addr_o(sd_addr),
    .ready_o(init_done), .busy_o(refresh_busy)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke = 1'b1;

  // R10
  no_pre_while_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && init_done) |-> (cmd == CMD_NOP));

endmodule

// File: tb/sdram_boot_refresh_tb_top.sv
module sdram_boot_refresh_tb_top;
  localparam int PWR = 10000, TRP = 1, TRC = 4, MRD = 3, NREF = 8, REFI = 781;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam int P0   = PWR + 1;
  localparam int MODE = P0 + TRP + NREF * TRC;
  localparam int RDY  = MODE + MRD;

  logic clk = 0, rst_n = 0, bus_req = 0;
  logic bus_gnt, cs_n, ras_n, cas_n, we_n, cke, init_done, refresh_busy;
  logic [11:0] addr;
  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [3:0] cmd; logic [11:0] addr; int at; string req; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  sdram_boot_refresh dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_addr(addr), .sd_cke(cke), .init_done(init_done), .refresh_busy(refresh_busy)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(string r, logic [31:0] act, logic [31:0] expv, string what);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", r, what, act, expv, cyc);
    end
  endtask

  task automatic push(logic [3:0] c, logic [11:0] a, int at, string r);
    exp_t e;
    e.cmd = c; e.addr = a; e.at = at; e.req = r;
    q.push_back(e);
  endtask

  task automatic wait_until(int n);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: every non-NOP command is popped from the scoreboard and compared.
  logic [3:0] mon_cmd;
  always @(negedge clk) begin
    mon_cmd = {cs_n, ras_n, cas_n, we_n};
    if (rst_n && !done && mon_cmd != NOP) begin
      if (q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R2 unexpected command: actual %b expected none (cycle %0d)", mon_cmd, cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.req, 32'(mon_cmd), 32'(e.cmd), "command code (R6)");
        check(e.req, 32'(addr), 32'(e.addr), "address");
        check(e.req, 32'(cyc), 32'(e.at), "issue cycle");
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc > 40000);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int d, b, r2;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", 32'({cs_n, ras_n, cas_n, we_n}), 32'(NOP), "reset command");
    check("R1", 32'(cke), 1, "reset cke");
    check("R1", 32'({init_done, refresh_busy, bus_gnt}), 0, "reset flags");
    rst_n = 1;

    // R2 R3 R4 start-up sequence
    push(PRE, 12'h400, P0, "R2");
    for (int i = 0; i < NREF; i++) push(REF, 12'h000, P0 + TRP + i * TRC, "R3");
    push(MRS, 12'h022, MODE, "R4");

    wait_until(100);
    bus_req = 1;
    wait_until(5000);
    check("R11", 32'(bus_gnt), 0, "grant before ready");
    check("R2", 32'(cke), 1, "cke during power-up");

    wait_until(RDY - 1);
    check("R5", 32'(init_done), 0, "ready one cycle early");
    wait_until(RDY);
    check("R5", 32'(init_done), 1, "ready on time");
    check("R11", 32'(bus_gnt), 0, "grant same cycle as ready");
    wait_until(RDY + 1);
    check("R9", 32'(bus_gnt), 1, "grant after ready");

    // Refresh falls due at RDY+REFI while the grant is held (R10).
    wait_until(RDY + REFI + 5);
    check("R10", 32'(refresh_busy), 0, "refresh deferred under grant");
    check("R9", 32'(bus_gnt), 1, "grant held across due refresh");
    d = RDY + REFI + 40;
    push(PRE, 12'h400, d + 2, "R10");
    push(REF, 12'h000, d + 2 + TRP, "R8");
    wait_until(d);
    bus_req = 0;
    wait_until(d + 1);
    check("R9", 32'(bus_gnt), 0, "grant falls after release");
    wait_until(d + 2);
    check("R8", 32'(refresh_busy), 1, "busy with precharge");
    wait_until(d + 3);
    bus_req = 1;
    b = d + 2 + TRP + TRC;
    wait_until(b - 1);
    check("R8", 32'(refresh_busy), 1, "busy through tRC");
    check("R10", 32'(bus_gnt), 0, "no grant while busy");
    wait_until(b);
    check("R8", 32'(refresh_busy), 0, "busy drops after tRC");
    check("R10", 32'(bus_gnt), 0, "no grant in busy-drop cycle");
    wait_until(b + 1);
    check("R9", 32'(bus_gnt), 1, "grant after refresh");
    wait_until(b + 10);
    bus_req = 0;
    wait_until(b + 11);
    check("R9", 32'(bus_gnt), 0, "grant released");

    // R7 periodic cadence with free bus
    r2 = RDY + 2 * REFI;
    push(PRE, 12'h400, r2 + 1, "R7");
    push(REF, 12'h000, r2 + 1 + TRP, "R8");
    push(PRE, 12'h400, r2 + REFI + 1, "R7");
    push(REF, 12'h000, r2 + REFI + 1 + TRP, "R8");
    wait_until(r2 + 1);
    check("R8", 32'(refresh_busy), 1, "busy on periodic refresh");
    wait_until(r2 + REFI + 20);
    check("R7", 32'(q.size()), 0, "scoreboard drained");
    check("R5", 32'(init_done), 1, "ready stays high");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule